// File: doc/BRIEF.md
# Sixteen-Bit Event-Clearable Timer/Counter

This block is a 16-bit up-counter that software reaches through a small byte-wide register port. It counts either every system clock cycle (timer mode) or rising edges of an external clock pin (counter mode). In counter mode the pin is either passed through a synchroniser chain or sampled through a single register stage. A 2-bit prescale field divides the selected source by 1, 2, 4 or 8. When the count wraps from 0xFFFF to 0x0000 a sticky overflow flag is raised. An external event trigger forces the count to zero.

Software sees the count as a low and a high byte. In the 8-bit access mode each byte is read and written directly. In the 16-bit access mode the high byte is staged in buffers, so that software gets and sets a coherent 16-bit value with two byte accesses. A read-only bit in the control byte reports an input that tells whether the device clock comes from the secondary oscillator.

Top module: `evt_timer16`

## Requirements
- R1: After a synchronous reset the control byte (apart from bit 6), both count bytes and the overflow flag all read 0.
- R2: Register map by `bus_addr`: 0 is the control byte, 1 is the count low byte, 2 is the count high byte, 3 is the flag register (bit 0 is the flag, writing bit 0 = 1 clears it). Control bits are: 7 wide access mode, 6 clock status (read-only), 5:4 prescale select, 3 oscillator enable (stored and read back with no effect on counting), 2 unsynchronised-input select, 1 external source select, 0 run. Writable control bits read back as written.
- R3: With prescale select p, the count advances once per 2^p source ticks. The prescaler is cleared by a control write, by a count byte write and by the event trigger.
- R4: In timer mode (bit 1 = 0) with run = 1, every clock cycle is one source tick. With run = 0 the count holds.
- R5: In counter mode (bit 1 = 1) each rising edge of `ext_clk` is one source tick. Bit 2 = 0 uses the synchroniser chain and bit 2 = 1 uses a single sample stage. The system clock alone does not advance the count in this mode.
- R6: An increment from 0xFFFF gives 0x0000 and sets the flag, which stays set until software writes 1 to flag bit 0. If the flag is set and cleared in the same cycle, the set wins.
- R7: A high `evt_trig` zeroes the count on the next edge. It takes priority over an increment and over a count byte write in the same cycle, and it never sets the flag.
- R8: In 8-bit access mode (bit 7 = 0), writes and reads of each count byte act on the count directly.
- R9: In 16-bit access mode a read of the low byte copies the count's high byte into a read buffer, and a read of the high byte returns that buffer.
- R10: In 16-bit access mode a high-byte write only loads a write buffer. The next low-byte write loads both bytes of the count at once.
- R11: Control bit 6 always reads the `sec_osc_sel` input, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (triggers the high-byte capture) |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| ext_clk | input | 1 | External count clock |
| evt_trig | input | 1 | Event trigger that clears the count |
| sec_osc_sel | input | 1 | High when the device clock comes from the secondary oscillator |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The bench sweeps every prescale setting over run lengths that are and are not multiples of the ratio. A divider that is off by one or slow to restart would give a wrong quotient. It counts external pulses in both synchronisation settings, and confirms that idle clocks do not count in counter mode.

The bench drives the event trigger in the same cycle as a wrap and in the same cycle as a byte write. A design with the wrong priority would leave a nonzero count or a raised flag. In 16-bit access mode the bench lets the count carry into the high byte between the low and high reads, and checks that the buffered value comes back. It also checks that a lone high write leaves the count alone. A design without the buffers would return a torn value or change the count too early.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;

    localparam int BYTE_W = 8;
    localparam int NBYTES = 2;
    localparam int CNT_W  = BYTE_W * NBYTES;
    localparam int PS_W   = 2;
    localparam int PRE_W  = (1 << PS_W) - 1;

    typedef enum logic [1:0] {
        ADR_CTRL = 2'd0,
        ADR_LOW  = 2'd1,
        ADR_HIGH = 2'd2,
        ADR_FLAG = 2'd3
    } addr_e;

    typedef struct packed {
        logic            wide_rw;
        logic            clk_stat;
        logic [PS_W-1:0] ps;
        logic            osc_en;
        logic            no_sync;
        logic            ext_src;
        logic            run;
    } ctrl_t;

    // Mask whose low 'ps' bits are set; the prescaler fires when they are all 1.
    function automatic logic [PRE_W-1:0] ps_mask(input logic [PS_W-1:0] ps);
        logic [PRE_W-1:0] m;
        m = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < int'(ps)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/evt_timer16_src.sv
module evt_timer16_src #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    input  logic ext_src,
    input  logic no_sync,
    output logic src_tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   raw_q;
    logic                   prev_q;
    logic                   sel;

    always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= ext_clk;
    end

    genvar gi;
    generate
        for (gi = 1; gi < SYNC_STAGES; gi++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst) sync_q[gi] <= 1'b0;
                else     sync_q[gi] <= sync_q[gi-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            raw_q  <= ext_clk;
            prev_q <= sel;
        end
    end

    assign sel      = no_sync ? raw_q : sync_q[SYNC_STAGES-1];
    assign src_tick = ext_src ? (sel & ~prev_q) : 1'b1;

    // R5: an external tick is a single-cycle pulse
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (ext_src && src_tick && $stable(ext_src) && $stable(no_sync)) |=> !(src_tick && ext_src));

endmodule

// File: rtl/evt_timer16_presc.sv
module evt_timer16_presc
    import evt_timer16_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            run,
    input  logic            tick_in,
    input  logic [PS_W-1:0] ps,
    output logic            tick_out
);
    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] mask;

    assign mask     = ps_mask(ps);
    assign tick_out = run & tick_in & ((cnt_q & mask) == mask);

    always_ff @(posedge clk) begin
        if (rst || clr)          cnt_q <= '0;
        else if (run && tick_in) cnt_q <= cnt_q + 1'b1;
    end

    // R3: at any ratio above 1:1, two outputs never come back to back
    a_r3_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick_out && ps != '0 && !clr) |=> !tick_out);

    // R4: nothing passes while stopped
    a_r4_stopped: assert property (@(posedge clk) disable iff (rst)
        !run |-> !tick_out);

endmodule

// File: rtl/evt_timer16_core.sv
module evt_timer16_core
    import evt_timer16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inc,
    input  logic              evt,
    input  logic              wide,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_lo,
    input  logic              flag_clr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [BYTE_W-1:0] hi_rd_q,
    output logic              flag_q
);
    logic [BYTE_W-1:0] hi_wr_q;
    logic              hi_direct;
    logic              load;
    logic              wrap;

    assign hi_direct = wr_hi & ~wide;
    assign load      = wr_lo | hi_direct;
    assign wrap      = inc & ~evt & ~load & (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            hi_wr_q <= '0;
            hi_rd_q <= '0;
        end else begin
            if (evt) begin
                cnt_q <= '0;
            end else if (wr_lo) begin
                cnt_q[BYTE_W-1:0] <= wdata;
                if (wide) cnt_q[CNT_W-1:BYTE_W] <= hi_wr_q;
            end else if (hi_direct) begin
                cnt_q[CNT_W-1:BYTE_W] <= wdata;
            end else if (inc) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (wr_hi && wide) hi_wr_q <= wdata;
            if (rd_lo && wide) hi_rd_q <= cnt_q[CNT_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           flag_q <= 1'b0;
        else if (wrap)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    a_r7_evt_zero: assert property (@(posedge clk) disable iff (rst)
        evt |=> (cnt_q == '0));

    a_r7_evt_no_flag: assert property (@(posedge clk) disable iff (rst)
        (evt && !flag_q) |=> !flag_q);

    a_r6_wrap_flag: assert property (@(posedge clk) disable iff (rst)
        (inc && !evt && !wr_lo && !wr_hi && cnt_q == {CNT_W{1'b1}}) |=> (flag_q && cnt_q == '0));

    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !flag_clr) |=> flag_q);

    a_r10_hi_buffered: assert property (@(posedge clk) disable iff (rst)
        (wr_hi && wide && !wr_lo && !evt && !inc) |=> $stable(cnt_q));

    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!inc && !evt && !wr_lo && !wr_hi) |=> $stable(cnt_q));

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
    import evt_timer16_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              ext_clk,
    input  logic              evt_trig,
    input  logic              sec_osc_sel,
    output logic              ovf_flag
);
    ctrl_t             ctrl_q;
    ctrl_t             ctrl_rd;
    addr_e             adr;
    logic              wr_ctrl, wr_lo, wr_hi, rd_lo, flag_clr;
    logic              src_tick, inc, presc_clr;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] hi_rd;

    assign adr      = addr_e'(bus_addr);
    assign wr_ctrl  = bus_wr && adr == ADR_CTRL;
    assign wr_lo    = bus_wr && adr == ADR_LOW;
    assign wr_hi    = bus_wr && adr == ADR_HIGH;
    assign rd_lo    = bus_rd && adr == ADR_LOW;
    assign flag_clr = bus_wr && adr == ADR_FLAG && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q          <= ctrl_t'(bus_wdata);
            ctrl_q.clk_stat <= 1'b0;
        end
    end

    assign presc_clr = wr_ctrl | wr_lo | wr_hi | evt_trig;

    evt_timer16_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk      (clk),
        .rst      (rst),
        .ext_clk  (ext_clk),
        .ext_src  (ctrl_q.ext_src),
        .no_sync  (ctrl_q.no_sync),
        .src_tick (src_tick)
    );

    evt_timer16_presc u_presc (
        .clk      (clk),
        .rst      (rst),
        .clr      (presc_clr),
        .run      (ctrl_q.run),
        .tick_in  (src_tick),
        .ps       (ctrl_q.ps),
        .tick_out (inc)
    );

    evt_timer16_core u_core (
        .clk      (clk),
        .rst      (rst),
        .inc      (inc),
        .evt      (evt_trig),
        .wide     (ctrl_q.wide_rw),
        .wr_lo    (wr_lo),
        .wr_hi    (wr_hi),
        .rd_lo    (rd_lo),
        .flag_clr (flag_clr),
        .wdata    (bus_wdata),
        .cnt_q    (cnt),
        .hi_rd_q  (hi_rd),
        .flag_q   (ovf_flag)
    );

    always_comb begin
        ctrl_rd          = ctrl_q;
        ctrl_rd.clk_stat = sec_osc_sel;
        unique case (adr)
            ADR_CTRL: bus_rdata = BYTE_W'(ctrl_rd);
            ADR_LOW:  bus_rdata = cnt[BYTE_W-1:0];
            ADR_HIGH: bus_rdata = ctrl_q.wide_rw ? hi_rd : cnt[CNT_W-1:BYTE_W];
            default:  bus_rdata = {{(BYTE_W-1){1'b0}}, ovf_flag};
        endcase
    end

    // R1: state after reset
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (ctrl_q == '0 && cnt == '0 && !ovf_flag));

    // R2: a control write is held until the next one
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl_q));

    // R11: the status field stored in the register stays clear
    a_r11_stat_ro: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_q.clk_stat == 1'b0));

endmodule

// File: tb/evt_timer16_bench.sv
module evt_timer16_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       ext_clk = 1'b0;
    logic       evt_trig = 1'b0;
    logic       sec_osc_sel = 1'b0;
    logic       ovf_flag;

    int checks = 0;
    int failures = 0;
    logic [7:0] v;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_timer16 u_evt_timer16 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ext_clk(ext_clk), .evt_trig(evt_trig), .sec_osc_sel(sec_osc_sel),
        .ovf_flag(ovf_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk = 1'b1;
            repeat (3) @(negedge clk);
            ext_clk = 1'b0;
            repeat (3) @(negedge clk);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
        rd(2'd1, v); chk("R1 low", v, 8'h00);
        rd(2'd2, v); chk("R1 high", v, 8'h00);
        rd(2'd3, v); chk("R1 flag reg", v, 8'h00);
        chk("R1 ovf_flag", ovf_flag, 0);

        // R3 / R4: prescale sweep in timer mode
        for (int ps = 0; ps < 4; ps++) begin
            for (int k = 0; k < 2; k++) begin
                int n;
                n = (k == 0) ? 40 : 37;
                wr(2'd1, 8'h00); wr(2'd2, 8'h00);
                wr(2'd0, 8'(ps << 4) | 8'h01);
                repeat (n - 1) @(negedge clk);
                wr(2'd0, 8'(ps << 4));
                rd(2'd1, v);
                chk(ps == 0 ? "R4 timer 1:1" : "R3 prescale", v, n >> ps);
                rd(2'd2, v); chk("R3 high byte", v, 0);
                repeat (10) @(negedge clk);
                rd(2'd1, v); chk("R4 hold when stopped", v, n >> ps);
            end
        end

        // R5: external counting, synchronised and not
        for (int as = 0; as < 2; as++) begin
            for (int ps = 0; ps < 4; ps += 2) begin
                wr(2'd1, 8'h00); wr(2'd2, 8'h00);
                wr(2'd0, 8'(ps << 4) | 8'(as << 2) | 8'h03);
                ext_pulses(8);
                repeat (6) @(negedge clk);
                wr(2'd0, 8'h00);
                rd(2'd1, v); chk("R5 ext pulses", v, 8 >> ps);
            end
        end
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h03);
        repeat (30) @(negedge clk);
        wr(2'd0, 8'h00);
        rd(2'd1, v); chk("R5 idle clocks ignored", v, 0);

        // R6: wrap sets sticky flag
        wr(2'd1, 8'hFE); wr(2'd2, 8'hFF);
        wr(2'd0, 8'h01);
        repeat (2) @(negedge clk);
        wr(2'd0, 8'h00);
        rd(2'd1, v); chk("R6 low after wrap", v, 8'h01);
        rd(2'd2, v); chk("R6 high after wrap", v, 8'h00);
        chk("R6 flag set", ovf_flag, 1);
        repeat (5) @(negedge clk);
        wr(2'd3, 8'h00);
        rd(2'd3, v); chk("R6 flag sticky", v, 8'h01);
        wr(2'd3, 8'h01);
        rd(2'd3, v); chk("R6 flag cleared", v, 8'h00);

        // R7: event trigger
        wr(2'd1, 8'h55); wr(2'd2, 8'h55);
        evt_trig = 1'b1; @(negedge clk); evt_trig = 1'b0;
        rd(2'd1, v); chk("R7 clear low", v, 0);
        rd(2'd2, v); chk("R7 clear high", v, 0);
        wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
        wr(2'd0, 8'h01);
        evt_trig = 1'b1; @(negedge clk); evt_trig = 1'b0;
        wr(2'd0, 8'h00);
        rd(2'd1, v); chk("R7 beats increment", v, 1);
        rd(2'd2, v); chk("R7 beats increment hi", v, 0);
        chk("R7 no flag", ovf_flag, 0);
        bus_wr = 1'b1; bus_addr = 2'd1; bus_wdata = 8'h77; evt_trig = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; evt_trig = 1'b0;
        rd(2'd1, v); chk("R7 beats write", v, 0);

        // R8: direct byte access
        wr(2'd1, 8'h34);
        rd(2'd1, v); chk("R8 low", v, 8'h34);
        wr(2'd2, 8'h12);
        rd(2'd2, v); chk("R8 high", v, 8'h12);
        rd(2'd1, v); chk("R8 low kept", v, 8'h34);

        // R10: buffered high write
        wr(2'd0, 8'h80);
        wr(2'd2, 8'hAB);
        rd(2'd1, v); chk("R10 low untouched", v, 8'h34);
        rd(2'd2, v); chk("R10 high not yet written", v, 8'h12);
        wr(2'd1, 8'hCD);
        rd(2'd1, v); chk("R10 low committed", v, 8'hCD);
        rd(2'd2, v); chk("R10 high committed", v, 8'hAB);

        // R9: coherent read across a carry
        wr(2'd2, 8'h12); wr(2'd1, 8'hFF);
        rd(2'd1, v); chk("R9 low", v, 8'hFF);
        wr(2'd0, 8'h81);
        repeat (2) @(negedge clk);
        wr(2'd0, 8'h80);
        rd(2'd2, v); chk("R9 buffered high", v, 8'h12);
        rd(2'd1, v); chk("R9 new low", v, 8'h02);
        rd(2'd2, v); chk("R9 new high", v, 8'h13);

        // R11 / R2: status bit and control readback
        sec_osc_sel = 1'b1;
        rd(2'd0, v); chk("R11 status reads input", v, 8'hC0);
        sec_osc_sel = 1'b0;
        wr(2'd0, 8'h48);
        rd(2'd0, v); chk("R11 status not writable", v, 8'h08);
        wr(2'd0, 8'hBE);
        rd(2'd0, v); chk("R2 ctrl readback", v, 8'hBE);
        wr(2'd0, 8'h00);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule